// File: doc/BRIEF.md
# Daisy-Chain Converter Serial Port

This block is the digital serial port of one sampling converter that runs in daisy-chain mode. It sees a conversion control line, a serial clock and a serial data input coming from the upstream converter, and it drives one serial data output. While the port is idle its output is held low. A rising edge on the conversion line, seen while the serial clock is low, starts a conversion and selects chain mode. A simple counter of system clocks stands in for the analog conversion time.

When the counter expires, the port copies the result word into a shift register and puts the word's most significant bit on the output at once. From then on, each falling edge of the serial clock moves the register one place toward the output and takes the serial input in at the far end. Several ports can therefore be wired output-to-input and read as one long shift register: the host gives the chain one falling edge per result bit for each converter. A falling edge on the conversion line ends the readback, or aborts a conversion in progress, and returns the port to idle.

All inputs are sampled on the system clock. The serial clock and the conversion line are edge-detected against their values at the previous system clock edge.

Top module: `chain_adc_port`

## Requirements
- R1: After reset the port is idle, `sdo` is 0 and `conv_start` is 0.
- R2: While the port is idle, `sdo` stays 0 whatever `sdi` does.
- R3: A rise of `cnv` that is sampled while `sck` is low starts a conversion. `conv_start` is 1 for exactly one cycle, the cycle after the edge that sampled the rise.
- R4: A rise of `cnv` that is sampled while `sck` is high starts nothing. `conv_start` stays 0 and `sdo` stays 0.
- R5: A conversion lasts `CONV_CYCLES` system clocks and `sdo` is 0 during it. At the clock edge that ends it, `result` is captured, and from the following cycle `sdo` shows bit `WIDTH-1` of the captured word. Later changes of `result` have no effect.
- R6: During readback a falling `sck` (sampled 1 then 0) shifts the register by one place. After k falls `sdo` shows captured bit `WIDTH-1-k`. A rising `sck` leaves `sdo` unchanged.
- R7: Each `sck` fall captures `sdi` into bit 0. After `WIDTH` or more falls, `sdo` presents the captured `sdi` values in the order they were taken.
- R8: `sck` edges that occur during a conversion have no effect on the word that is later shifted out.
- R9: A fall of `cnv` during a conversion or a readback returns the port to idle: `sdo` is 0 from the next cycle, and an aborted conversion never presents data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv | input | 1 | Conversion control line |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the upstream port |
| result | input | WIDTH | Result word, captured when the conversion ends |
| sdo | output | 1 | Serial data toward the downstream port or the host |
| conv_start | output | 1 | One-cycle pulse that starts the conversion timer |

## Verification
Each input change that the bench applies on a falling system-clock edge is seen at the next rising edge. Its effect is then read on the falling edge that follows: `conv_start` one cycle after the `cnv` rise, `sdo` zero one cycle after a `cnv` fall, and a new `sdo` bit one cycle after each sampled `sck` fall. The first data bit is due `CONV_CYCLES` cycles after the starting edge, so the bench checks `sdo` both one cycle before that point (still 0) and at that point. Every other check in the bench also reads its value on the falling edge that follows the rising edge on which the result is due.

// File: rtl/chain_adc_port.sv
module chain_adc_port #(
  parameter int WIDTH       = 14,
  parameter int CONV_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv,
  input  logic             sck,
  input  logic             sdi,
  input  logic [WIDTH-1:0] result,
  output logic             sdo,
  output logic             conv_start
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  typedef enum logic [1:0] {IDLE, CONV, READ} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [WIDTH-1:0] shreg;
  logic            cnv_q, sck_q;
  logic            in_idle, in_conv, in_read;
  logic            cnv_rise, cnv_fall, sck_fall;

  assign cnv_rise = cnv & ~cnv_q;
  assign cnv_fall = ~cnv & cnv_q;
  assign sck_fall = ~sck & sck_q;
  assign in_idle  = (st == IDLE);
  assign in_conv  = (st == CONV);
  assign in_read  = (st == READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      shreg <= '0;
      cnv_q <= 1'b1;
      sck_q <= 1'b1;
    end else begin
      cnv_q <= cnv;
      sck_q <= sck;
      case (st)
        IDLE: if (cnv_rise && !sck) begin
          st  <= CONV;
          cnt <= '0;
        end
        CONV: begin
          if (cnv_fall) st <= IDLE;
          else if (cnt == LAST) begin
            st    <= READ;
            shreg <= result;
          end else cnt <= cnt + 1'b1;
        end
        READ: begin
          if (cnv_fall) st <= IDLE;
          else if (sck_fall) shreg <= {shreg[WIDTH-2:0], sdi};
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign sdo        = in_read & shreg[WIDTH-1];
  assign conv_start = in_conv && (cnt == '0);
endmodule

module chain_adc_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cnv,
  input logic sck,
  input logic sdo,
  input logic conv_start,
  input logic in_idle,
  input logic in_conv,
  input logic in_read,
  input logic sck_fall,
  input logic cnv_fall,
  input logic next_bit
);
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sdo);

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_start_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($past(cnv) && !$past(sck)));

  p_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && sck) |=> !in_conv);

  p_conv_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_conv |-> !sdo);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read && !sck_fall && !cnv_fall) |=> $stable(sdo));

  p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read && sck_fall && !cnv_fall) |=> (sdo == $past(next_bit)));

  p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_read || in_conv) && cnv_fall) |=> (in_idle && !sdo));
endmodule

bind chain_adc_port chain_adc_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdo(sdo),
  .conv_start(conv_start), .in_idle(in_idle), .in_conv(in_conv),
  .in_read(in_read), .sck_fall(sck_fall), .cnv_fall(cnv_fall),
  .next_bit(shreg[WIDTH-2])
);

// File: tb/chain_adc_port_tb.sv
`timescale 1ns/1ps
module chain_adc_port_tb;
  localparam int W = 14;
  localparam int C = 20;

  logic clk = 1'b0, rst_n = 1'b0, cnv = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [W-1:0] result = '0;
  logic sdo, conv_start;
  int total = 0, bad = 0, starts = 0;
  bit done = 0;
  logic hist [64];

  always #2.5 clk = ~clk;

  chain_adc_port #(.WIDTH(W), .CONV_CYCLES(C)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi),
    .result(result), .sdo(sdo), .conv_start(conv_start));

  always @(negedge clk) if (conv_start) starts++;

  function automatic logic exp_bit(input logic [W-1:0] word, input int k);
    if (k < W) return word[W-1-k];
    return hist[k-W];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic start_conv(input logic [W-1:0] word);
    @(negedge clk);
    result = word; cnv = 1'b1; sck = 1'b0;
    for (int i = 0; i <= C; i++) begin
      tick();
      if (i == 0) chk("R3 pulse", conv_start, 1'b1);
      if (i == 1) chk("R3 single", conv_start, 1'b0);
      if (i == C-1) chk("R5 low during conversion", sdo, 1'b0);
      if (i == C) chk("R5 first bit", sdo, word[W-1]);
      sck = (i < C-2) ? 1'($urandom_range(0, 1)) : 1'b0; // R8
      if (i == C) result = W'($urandom);
    end
  endtask

  task automatic readback(input logic [W-1:0] word, input int nfalls);
    for (int k = 1; k <= nfalls; k++) begin
      sck = 1'b1; sdi = 1'($urandom_range(0, 1)); hist[k-1] = sdi;
      tick();
      chk("R6 rise holds", sdo, exp_bit(word, k-1));
      sck = 1'b0;
      tick();
      if (k < W) chk("R6 shift", sdo, exp_bit(word, k));
      else chk("R7 upstream bit", sdo, exp_bit(word, k));
    end
    cnv = 1'b0;
    tick();
    chk("R9 end readback", sdo, 1'b0);
    for (int i = 0; i < 4; i++) begin
      sdi = 1'($urandom_range(0, 1));
      tick();
      chk("R2 idle low", sdo, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 sdo reset", sdo, 1'b0);
    chk("R1 start reset", conv_start, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R1 idle", sdo, 1'b0);

    start_conv(14'h3FFF); readback(14'h3FFF, W + 4);
    start_conv(14'h0000); readback(14'h0000, W + 6);
    start_conv(14'h2AAA); readback(14'h2AAA, W);
    for (int f = 0; f < 6; f++) begin
      logic [W-1:0] w;
      w = W'($urandom);
      start_conv(w);
      readback(w, $urandom_range(3, 30));
    end

    begin : r4_blk
      int s0;
      s0 = starts;
      sck = 1'b1; cnv = 1'b1;
      for (int i = 0; i < C + 4; i++) begin
        tick();
        chk("R4 no data", sdo, 1'b0);
      end
      chk("R4 no start", 1'(starts != s0), 1'b0);
      cnv = 1'b0; sck = 1'b0;
      tick();
    end

    begin : r9_blk
      cnv = 1'b1; result = 14'h3FFF;
      tick();
      chk("R9 abort start", conv_start, 1'b1);
      repeat (3) tick();
      cnv = 1'b0;
      for (int i = 0; i < C + 4; i++) begin
        tick();
        chk("R9 abort no data", sdo, 1'b0);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule